// File: doc/BRIEF.md
# Relocatable Peripheral Register Window

This block places a 256-byte window of peripheral control registers on a bus with 20-bit addresses and 16-bit data. A relocation register sets where the window sits. Its low twelve bits give address bits 19:8 of a 256-byte-aligned base. One bit selects whether the window answers memory accesses or I/O accesses. Every bus access is compared against the window combinationally. The block drives a hit flag and the byte offset inside the window, and on a read it returns the data of the addressed register in the same cycle.

Three registers live inside the window. The first is the relocation register, which software can read and write. The second is a configuration snapshot register, which holds the value of sixteen external pins as they stood in the last clock cycle of reset. The third is a fixed release-level register. Bit 14 of the relocation register is not used by the decoder. It is brought out as a mode output that a neighbouring interrupt controller reads: 1 means slave and 0 means master. Reset is synchronous and active high.

Top module: `pcb_window_top`

## Requirements
- R1: After reset the relocation register holds 0x20FF. The window is then in I/O space at base 0xFF00, and a read of I/O address 0xFFFE returns 0x20FF.
- R2: When relocation bit 12 is 1, a valid memory access hits exactly when address bits 19:8 equal relocation bits 11:0. I/O accesses never hit.
- R3: When relocation bit 12 is 0, a valid I/O access hits exactly when address bits 15:8 equal relocation bits 7:0. Address bits 19:16 and relocation bits 11:8 play no part. Memory accesses never hit.
- R4: On a hit, the offset output equals address bits 7:0. With no hit, or with no valid access, the hit output is 0 and the read data is 0.
- R5: The snapshot register at offset 0xF6 holds the pin value sampled on the last clock edge with reset high. It keeps that value until the next reset, whatever the pins do in between.
- R6: A read at offset 0xF4 returns 0x0400.
- R7: Writes at offsets 0xF4 and 0xF6 change nothing.
- R8: A write at offset 0xFE stores all 16 bits, including the reserved bits 15 and 13, and they read back unchanged. Bit 14 drives the slave-mode output.
- R9: A relocation write takes effect for decoding from the very next access: the old window stops hitting and the new window hits.
- R10: Reads at any other offset inside the window return 0, and writes there change nothing.
- R11: A write that does not hit the window leaves the relocation register unchanged, even if its low address bits are 0xFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; pins are snapshotted while it is high |
| cfg_pins | input | 16 | External configuration pins |
| bus_valid | input | 1 | An access is presented this cycle |
| bus_is_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 20 | Access address |
| bus_wdata | input | 16 | Write data |
| win_hit | output | 1 | The access falls inside the window |
| win_offset | output | 8 | Byte offset of the access inside the window |
| bus_rdata | output | 16 | Read data for a read hit, else 0 |
| irq_slave | output | 1 | Interrupt-controller mode: 1 slave, 0 master |

## Verification
The bench sweeps every value of the upper twelve address bits in both access spaces, for four window placements. It checks hit, offset and read data against an arithmetic model at each point. This catches a decoder that compares bits 19:16 in I/O space, ignores the space bit, or lets a window answer both spaces. It moves the window and probes the old and new addresses in the next cycle, which exposes a one-cycle-late update. It also writes through addresses that end in 0xFE but sit outside the window, which exposes a decoder that keys writes on the offset alone. Two resets with different pin values, followed by changes to the pins, would show a snapshot register that keeps tracking the pins or that loads on the wrong edge.

// File: rtl/pcb_win_pkg.sv
package pcb_win_pkg;

    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 16;
    localparam int OFF_W      = 8;
    localparam int IO_ADDR_W  = 16;
    localparam int BASE_W     = ADDR_W - OFF_W;
    localparam int IO_BASE_W  = IO_ADDR_W - OFF_W;
    localparam int SPACE_BIT  = 12;
    localparam int SLAVE_BIT  = 14;

    localparam logic [DATA_W-1:0] RELOC_RST = 16'h20FF;
    localparam logic [DATA_W-1:0] LEVEL_VAL = 16'h0400;

    localparam logic [OFF_W-1:0] OFF_RELOC = 8'hFE;
    localparam logic [OFF_W-1:0] OFF_SNAP  = 8'hF6;
    localparam logic [OFF_W-1:0] OFF_LEVEL = 8'hF4;

    typedef struct packed {
        logic              valid;
        logic              is_io;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RELOC,
        SEL_SNAP,
        SEL_LEVEL
    } reg_sel_t;

    function automatic reg_sel_t offset_to_sel(input logic [OFF_W-1:0] off);
        case (off)
            OFF_RELOC: return SEL_RELOC;
            OFF_SNAP:  return SEL_SNAP;
            OFF_LEVEL: return SEL_LEVEL;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pcb_win_decode.sv
module pcb_win_decode
    import pcb_win_pkg::*;
(
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] reloc,
    output logic              hit,
    output logic [OFF_W-1:0]  offset,
    output reg_sel_t          sel
);
    logic              mem_space;
    logic [BASE_W-1:0] base;
    logic              mem_match;
    logic              io_match;

    always_comb begin
        mem_space = reloc[SPACE_BIT];
        base      = reloc[BASE_W-1:0];
        mem_match = (req.addr[ADDR_W-1:OFF_W] == base);
        io_match  = (req.addr[IO_ADDR_W-1:OFF_W] == base[IO_BASE_W-1:0]);
        if (mem_space)
            hit = req.valid && !req.is_io && mem_match;
        else
            hit = req.valid && req.is_io && io_match;
        offset = req.addr[OFF_W-1:0];
        sel    = hit ? offset_to_sel(offset) : SEL_NONE;
    end
endmodule

// File: rtl/pcb_win_reloc.sv
module pcb_win_reloc
    import pcb_win_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = RELOC_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (we)
            q <= wdata;
    end

    // R11: without a qualified write the window cannot move
    p_reloc_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/pcb_win_snap.sv
module pcb_win_snap
    import pcb_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= pins;
    end

    // R5: the snapshot is frozen once reset is released
    p_snap_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(q));
endmodule

// File: rtl/pcb_window_top.sv
module pcb_window_top
    import pcb_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cfg_pins,
    input  logic              bus_valid,
    input  logic              bus_is_io,
    input  logic              bus_wr,
    input  logic [19:0]       bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic              win_hit,
    output logic [7:0]        win_offset,
    output logic [15:0]       bus_rdata,
    output logic              irq_slave
);
    bus_req_t          req;
    reg_sel_t          sel;
    logic [DATA_W-1:0] reloc_q;
    logic [DATA_W-1:0] snap_q;
    logic              reloc_we;

    always_comb begin
        req.valid = bus_valid;
        req.is_io = bus_is_io;
        req.wr    = bus_wr;
        req.addr  = bus_addr;
        req.wdata = bus_wdata;
    end

    pcb_win_decode u_decode (
        .req    (req),
        .reloc  (reloc_q),
        .hit    (win_hit),
        .offset (win_offset),
        .sel    (sel)
    );

    assign reloc_we = req.wr && (sel == SEL_RELOC);

    pcb_win_reloc #(.RST_VAL(RELOC_RST)) u_reloc (
        .clk   (clk),
        .rst   (rst),
        .we    (reloc_we),
        .wdata (req.wdata),
        .q     (reloc_q)
    );

    pcb_win_snap u_snap (
        .clk  (clk),
        .rst  (rst),
        .pins (cfg_pins),
        .q    (snap_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (!req.wr) begin
            case (sel)
                SEL_RELOC: bus_rdata = reloc_q;
                SEL_SNAP:  bus_rdata = snap_q;
                SEL_LEVEL: bus_rdata = LEVEL_VAL;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq_slave = reloc_q[SLAVE_BIT];

    // R2: a hit always agrees with the selected space
    p_space_agree_r2: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> (bus_is_io != reloc_q[SPACE_BIT]));

    // R3: in I/O space only address bits 15:8 are compared
    p_io_upper_free_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_is_io && !reloc_q[SPACE_BIT]
         && bus_addr[15:8] == reloc_q[7:0]) |-> win_hit);

    // R4: nothing is driven on the read bus without a hit
    p_quiet_miss_r4: assert property (@(posedge clk) disable iff (rst)
        !win_hit |-> (bus_rdata == '0));

    // R6: the release level is constant
    p_level_const_r6: assert property (@(posedge clk) disable iff (rst)
        (win_hit && !bus_wr && bus_addr[7:0] == 8'hF4) |-> (bus_rdata == 16'h0400));
endmodule

// File: tb/test_pcb_window_top.sv
module test_pcb_window_top;
    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_pins = 16'h0;
    logic        bus_valid = 1'b0;
    logic        bus_is_io = 1'b0;
    logic        bus_wr = 1'b0;
    logic [19:0] bus_addr = 20'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic        win_hit;
    logic [7:0]  win_offset;
    logic [15:0] bus_rdata;
    logic        irq_slave;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] rel_m;
    logic [15:0] snap_m;

    always #(PERIOD/2) clk = ~clk;

    pcb_window_top i_pcb_window_top (
        .clk(clk), .rst(rst), .cfg_pins(cfg_pins),
        .bus_valid(bus_valid), .bus_is_io(bus_is_io), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .win_hit(win_hit), .win_offset(win_offset),
        .bus_rdata(bus_rdata), .irq_slave(irq_slave)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_hit(input logic [15:0] r, input logic io, input logic [19:0] a);
        if (r[12]) return !io && (a[19:8] == r[11:0]);
        return io && (a[15:8] == r[7:0]);
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] r, input logic io, input logic [19:0] a);
        if (!exp_hit(r, io, a)) return 16'h0;
        case (a[7:0])
            8'hFE:   return r;
            8'hF6:   return snap_m;
            8'hF4:   return 16'h0400;
            default: return 16'h0;
        endcase
    endfunction

    // Address of a register in the current window
    function automatic logic [19:0] win_addr(input logic [7:0] off);
        if (rel_m[12]) return {rel_m[11:0], off};
        return {4'h0, rel_m[7:0], off};
    endfunction

    task automatic do_reset(input logic [15:0] pins);
        @(negedge clk);
        bus_valid = 1'b0;
        rst = 1'b1;
        cfg_pins = pins;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cfg_pins = ~pins;
        snap_m = pins;
        rel_m = 16'h20FF;
    endtask

    task automatic rd(input logic io, input logic [19:0] a);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_is_io = io;
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
    endtask

    task automatic wr(input logic io, input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_is_io = io;
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        if (exp_hit(rel_m, io, a) && a[7:0] == 8'hFE) rel_m = d;
    endtask

    task automatic move_window(input logic [15:0] nrel);
        wr(!rel_m[12], win_addr(8'hFE), nrel);
    endtask

    task automatic sweep(input string tag);
        for (int hi = 0; hi < 4096; hi++) begin
            for (int io = 0; io < 2; io++) begin
                logic [19:0] a;
                a = {hi[11:0], 8'(hi * 37 + io * 11)};
                rd(io[0], a);
                chk(tag, {31'h0, win_hit}, {31'h0, exp_hit(rel_m, io[0], a)});
                if (exp_hit(rel_m, io[0], a)) chk("R4 offset", {24'h0, win_offset}, {24'h0, a[7:0]});
                chk("R4 rdata", {16'h0, bus_rdata}, {16'h0, exp_rd(rel_m, io[0], a)});
            end
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        do_reset(16'hA5C3);

        // R1 reset state
        rd(1'b1, 20'h0FFFE);
        chk("R1 reloc reset", {16'h0, bus_rdata}, 32'h20FF);
        chk("R1 hit", {31'h0, win_hit}, 32'h1);
        chk("R8 slave reset", {31'h0, irq_slave}, 32'h0);
        // R3 upper I/O bits ignored
        rd(1'b1, 20'h9FFFE);
        chk("R3 upper ignored", {16'h0, bus_rdata}, 32'h20FF);
        // R5 snapshot after pins changed
        rd(1'b1, 20'h0FFF6);
        chk("R5 snapshot", {16'h0, bus_rdata}, 32'hA5C3);
        // R6 level
        rd(1'b1, 20'h0FFF4);
        chk("R6 level", {16'h0, bus_rdata}, 32'h0400);
        // R10 unimplemented read
        rd(1'b1, 20'h0FF80);
        chk("R10 unimpl read", {16'h0, bus_rdata}, 32'h0);
        // R4 not valid
        @(negedge clk); bus_valid = 1'b0; bus_is_io = 1'b1; bus_addr = 20'h0FFFE; #1;
        chk("R4 idle hit", {31'h0, win_hit}, 32'h0);
        chk("R4 idle rdata", {16'h0, bus_rdata}, 32'h0);

        sweep("R3 io sweep");

        // R7 writes to read-only registers
        wr(1'b1, 20'h0FFF6, 16'h1111);
        wr(1'b1, 20'h0FFF4, 16'h2222);
        wr(1'b1, 20'h0FF10, 16'h3333);
        rd(1'b1, 20'h0FFF6);
        chk("R7 snapshot ro", {16'h0, bus_rdata}, 32'hA5C3);
        rd(1'b1, 20'h0FFF4);
        chk("R7 level ro", {16'h0, bus_rdata}, 32'h0400);
        rd(1'b1, 20'h0FF10);
        chk("R10 unimpl write", {16'h0, bus_rdata}, 32'h0);
        rd(1'b1, 20'h0FFFE);
        chk("R10 reloc untouched", {16'h0, bus_rdata}, 32'h20FF);

        // R11 writes outside the window
        wr(1'b0, 20'h0FFFE, 16'h1123);
        wr(1'b1, 20'h0EEFE, 16'h1123);
        rd(1'b1, 20'h0FFFE);
        chk("R11 miss write", {16'h0, bus_rdata}, 32'h20FF);

        // R9 move to memory base 0x12300
        move_window(16'h1123);
        rd(1'b1, 20'h0FFFE);
        chk("R9 old window gone", {31'h0, win_hit}, 32'h0);
        rd(1'b0, 20'h123FE);
        chk("R9 new window", {16'h0, bus_rdata}, 32'h1123);
        rd(1'b0, 20'h023FE);
        chk("R2 full compare", {31'h0, win_hit}, 32'h0);
        sweep("R2 mem sweep");

        // R8 reserved bits and slave bit
        move_window(16'hF0AB);
        rd(1'b0, 20'h0ABFE);
        chk("R8 readback", {16'h0, bus_rdata}, 32'hF0AB);
        chk("R8 slave", {31'h0, irq_slave}, 32'h1);
        sweep("R2 mem sweep b");

        // R3 I/O with base bits 11:8 nonzero
        move_window(16'h0A5C);
        rd(1'b1, 20'h35CFE);
        chk("R3 base hi ignored", {16'h0, bus_rdata}, 32'h0A5C);
        chk("R8 master", {31'h0, irq_slave}, 32'h0);
        sweep("R3 io sweep b");

        // R5 second reset with new pins
        do_reset(16'h5A3C);
        rd(1'b1, 20'h0FFF6);
        chk("R5 second snapshot", {16'h0, bus_rdata}, 32'h5A3C);
        rd(1'b1, 20'h0FFFE);
        chk("R1 reloc after reset", {16'h0, bus_rdata}, 32'h20FF);

        @(negedge clk);
        bus_valid = 1'b0;
        finish_up();
    end
endmodule